// File: doc/BRIEF.md
# Divergent Warp Regrouping Pool

This block collects partial warps that a divergent branch has split apart and packs them back into fuller warps before they go to issue. Each incoming partial warp carries a program counter, a lane mask and one thread id per lane. The pool keeps a small set of entries. An arriving warp whose PC matches a held entry is folded into that entry, provided that no lane is used by both. Threads never move between lanes, so two partial warps can combine only when their masks do not overlap. The merged warp has more active lanes than either of its parts.

On the output side the pool offers one formed warp at a time with a valid/ready handshake. It always offers the entry with the most active lanes, so the execution lanes see the best packing the pool currently holds. The entry is released when the consumer accepts it. Inserts and issues can happen in the same cycle. An insert is never folded into the entry that is leaving in that cycle.

Top module: `warp_merge_pool`

## Requirements
- R1: After reset the pool is empty: `out_valid` is 0, and `in_ready` is 1 for any PC and mask.
- R2: An insert with a non-zero mask is merged into the lowest-index valid entry whose PC equals `in_pc` and whose mask shares no set bit with `in_mask`. The entry's mask becomes the OR of both masks. Thread id slot k (bits k*TID_W and up of the thread-id bus) of that entry takes the incoming id for every lane k set in `in_mask`, and keeps its old id otherwise.
- R3: An insert whose PC matches no entry, or whose mask overlaps every same-PC entry, takes the lowest-index free entry.
- R4: When no merge is possible and no entry is free, `in_ready` is 0 and the held warps are unchanged. A later insert that can merge is still accepted while the pool is full.
- R5: `out_valid` is 1 whenever any entry is held. The offered warp is the held entry with the most set mask bits; among equal counts, the lowest index wins.
- R6: While `out_valid` is 1 and `out_ready` is 0, and no insert is taken, the offered PC and mask stay the same. A warp accepted with `out_valid && out_ready` is removed from the pool and is never offered again.
- R7: When an issue and an insert are taken in the same cycle, the insert is not merged into the entry being issued. It merges into another matching entry or takes a free one.
- R8: An insert with an all-zero mask is accepted (`in_ready` 1) and dropped, and it never creates an entry.
- R9: Thread-id slots of lanes that are clear in `out_mask` read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Insert request present |
| in_ready | output | 1 | Insert can be taken this cycle |
| in_pc | input | PC_W | PC of the incoming partial warp |
| in_mask | input | LANES | Active lanes of the incoming partial warp |
| in_tids | input | LANES*TID_W | Thread id per lane, lane k in slot k |
| out_valid | output | 1 | A formed warp is offered |
| out_ready | input | 1 | Consumer accepts the offered warp |
| out_pc | output | PC_W | PC of the offered warp |
| out_mask | output | LANES | Merged lane mask of the offered warp |
| out_tids | output | LANES*TID_W | Thread id per lane of the offered warp |

## Verification
The bench sends warps with the same PC and disjoint masks, which must fold together, and warps with the same PC but overlapping masks, which must stay apart. Warps with distinct PCs must each take their own entry. Filling the pool with single-lane warps of distinct PCs separates a full-pool rejection from a merge that must still succeed. The same fill also exposes the lowest-index tie-break between entries of equal size. An issue paired with a same-PC disjoint insert in one cycle shows whether the leaving entry was wrongly chosen as the merge target. Empty-mask inserts show whether an entry is created that should not exist.

// File: rtl/dwf_pkg.sv
package dwf_pkg;

  localparam int unsigned MAX_LANES = 64;

  // number of active lanes in a (zero-extended) mask
  function automatic int unsigned lane_count(input logic [MAX_LANES-1:0] m);
    int unsigned n;
    n = 0;
    for (int k = 0; k < MAX_LANES; k++) n += int'(m[k]);
    return n;
  endfunction

  // true when no lane is claimed by both masks
  function automatic logic lanes_disjoint(input logic [MAX_LANES-1:0] a,
                                          input logic [MAX_LANES-1:0] b);
    return (a & b) == '0;
  endfunction

endpackage

// File: rtl/dwf_match.sv
module dwf_match #(
  parameter int ENTRIES = 8,
  parameter int LANES   = 8,
  parameter int PC_W    = 16
) (
  input  logic [ENTRIES-1:0]         valid_i,
  input  logic [ENTRIES*PC_W-1:0]    pc_i,
  input  logic [ENTRIES*LANES-1:0]   mask_i,
  input  logic [PC_W-1:0]            in_pc,
  input  logic [LANES-1:0]           in_mask,
  input  logic                       block_en,
  input  logic [$clog2(ENTRIES)-1:0] block_idx,
  output logic                       merge_hit,
  output logic [$clog2(ENTRIES)-1:0] merge_idx,
  output logic                       free_hit,
  output logic [$clog2(ENTRIES)-1:0] free_idx
);
  import dwf_pkg::*;
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] cand;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cand
    always_comb begin
      logic [MAX_LANES-1:0] a, b;
      a = '0;
      b = '0;
      a[LANES-1:0] = mask_i[i*LANES +: LANES];
      b[LANES-1:0] = in_mask;
      cand[i] = valid_i[i]
              && (pc_i[i*PC_W +: PC_W] == in_pc)
              && lanes_disjoint(a, b)
              && !(block_en && (block_idx == IDX_W'(i)));
    end
  end

  // scan downwards so the lowest index is the last one written
  always_comb begin
    merge_hit = 1'b0;
    merge_idx = '0;
    free_hit  = 1'b0;
    free_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (cand[i]) begin
        merge_hit = 1'b1;
        merge_idx = IDX_W'(i);
      end
      if (!valid_i[i]) begin
        free_hit = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/dwf_pick.sv
module dwf_pick #(
  parameter int ENTRIES = 8,
  parameter int LANES   = 8
) (
  input  logic [ENTRIES-1:0]         valid_i,
  input  logic [ENTRIES*LANES-1:0]   mask_i,
  output logic                       sel_valid,
  output logic [$clog2(ENTRIES)-1:0] sel_idx
);
  import dwf_pkg::*;
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int CNT_W = $clog2(LANES + 1);

  logic [CNT_W-1:0] cnt [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cnt
    always_comb begin
      logic [MAX_LANES-1:0] m;
      m = '0;
      m[LANES-1:0] = mask_i[i*LANES +: LANES];
      cnt[i] = CNT_W'(lane_count(m));
    end
  end

  // strict greater-than keeps the lowest index on a tie
  always_comb begin
    logic [CNT_W-1:0] best;
    best      = '0;
    sel_valid = 1'b0;
    sel_idx   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (valid_i[i] && (!sel_valid || cnt[i] > best)) begin
        sel_valid = 1'b1;
        sel_idx   = IDX_W'(i);
        best      = cnt[i];
      end
    end
  end

endmodule

// File: rtl/warp_merge_pool.sv
module warp_merge_pool #(
  parameter int ENTRIES = 8,
  parameter int LANES   = 8,
  parameter int PC_W    = 16,
  parameter int TID_W   = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [PC_W-1:0]        in_pc,
  input  logic [LANES-1:0]       in_mask,
  input  logic [LANES*TID_W-1:0] in_tids,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [PC_W-1:0]        out_pc,
  output logic [LANES-1:0]       out_mask,
  output logic [LANES*TID_W-1:0] out_tids
);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int TIDS_W = LANES * TID_W;

  // per-lane select: lanes set in sel take the new id, the rest keep old
  function automatic logic [TIDS_W-1:0] lane_merge(input logic [TIDS_W-1:0] old_ids,
                                                   input logic [TIDS_W-1:0] new_ids,
                                                   input logic [LANES-1:0]  sel);
    logic [TIDS_W-1:0] r;
    r = old_ids;
    for (int k = 0; k < LANES; k++)
      if (sel[k]) r[k*TID_W +: TID_W] = new_ids[k*TID_W +: TID_W];
    return r;
  endfunction

  logic [ENTRIES-1:0] valid_q;
  logic [PC_W-1:0]    pc_q   [ENTRIES];
  logic [LANES-1:0]   mask_q [ENTRIES];
  logic [TIDS_W-1:0]  tid_q  [ENTRIES];

  logic [ENTRIES*PC_W-1:0]  pc_flat;
  logic [ENTRIES*LANES-1:0] mask_flat;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_flat
    assign pc_flat[i*PC_W +: PC_W]    = pc_q[i];
    assign mask_flat[i*LANES +: LANES] = mask_q[i];
  end

  // named internal events
  logic             issue_fire;
  logic             insert_fire;
  logic             in_empty;
  logic             merge_hit;
  logic             free_hit;
  logic             do_merge;
  logic             do_alloc;
  logic [IDX_W-1:0] merge_idx;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] iss_idx;

  dwf_pick #(
    .ENTRIES(ENTRIES),
    .LANES  (LANES)
  ) u_pick (
    .valid_i  (valid_q),
    .mask_i   (mask_flat),
    .sel_valid(out_valid),
    .sel_idx  (iss_idx)
  );

  assign issue_fire = out_valid && out_ready;

  dwf_match #(
    .ENTRIES(ENTRIES),
    .LANES  (LANES),
    .PC_W   (PC_W)
  ) u_match (
    .valid_i  (valid_q),
    .pc_i     (pc_flat),
    .mask_i   (mask_flat),
    .in_pc    (in_pc),
    .in_mask  (in_mask),
    .block_en (issue_fire),
    .block_idx(iss_idx),
    .merge_hit(merge_hit),
    .merge_idx(merge_idx),
    .free_hit (free_hit),
    .free_idx (free_idx)
  );

  assign in_empty    = (in_mask == '0);
  assign in_ready    = in_empty || merge_hit || free_hit;
  assign insert_fire = in_valid && in_ready;
  assign do_merge    = insert_fire && !in_empty && merge_hit;
  assign do_alloc    = insert_fire && !in_empty && !merge_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        pc_q[i]   <= '0;
        mask_q[i] <= '0;
        tid_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (issue_fire && iss_idx == IDX_W'(i)) begin
          valid_q[i] <= 1'b0;
        end else if (do_alloc && free_idx == IDX_W'(i)) begin
          valid_q[i] <= 1'b1;
          pc_q[i]    <= in_pc;
          mask_q[i]  <= in_mask;
          tid_q[i]   <= lane_merge('0, in_tids, in_mask);
        end else if (do_merge && merge_idx == IDX_W'(i)) begin
          mask_q[i]  <= mask_q[i] | in_mask;
          tid_q[i]   <= lane_merge(tid_q[i], in_tids, in_mask);
        end
      end
    end
  end

  assign out_pc   = pc_q[iss_idx];
  assign out_mask = mask_q[iss_idx];
  assign out_tids = tid_q[iss_idx];

endmodule

// File: rtl/dwf_checker.sv
module dwf_checker #(
  parameter int ENTRIES = 8,
  parameter int LANES   = 8,
  parameter int PC_W    = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       in_ready,
  input logic                       out_valid,
  input logic                       out_ready,
  input logic [PC_W-1:0]            out_pc,
  input logic [LANES-1:0]           out_mask,
  input logic                       issue_fire,
  input logic                       insert_fire,
  input logic                       merge_hit,
  input logic [$clog2(ENTRIES)-1:0] merge_idx,
  input logic [$clog2(ENTRIES)-1:0] iss_idx,
  input logic [ENTRIES-1:0]         valid_q
);

  assert_ready_when_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  assert_reject_keeps_pool_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !issue_fire) |=> $stable(valid_q));

  assert_offer_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !insert_fire) |=>
      (out_valid && $stable(out_pc) && $stable(out_mask)));

  assert_issued_entry_freed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |=> !valid_q[$past(iss_idx)]);

  assert_no_merge_into_issued_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_fire && insert_fire && merge_hit) |-> (merge_idx != iss_idx));

  assert_no_empty_offer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_mask != '0));

endmodule

bind warp_merge_pool dwf_checker #(
  .ENTRIES(ENTRIES),
  .LANES  (LANES),
  .PC_W   (PC_W)
) u_dwf_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_pc     (out_pc),
  .out_mask   (out_mask),
  .issue_fire (issue_fire),
  .insert_fire(insert_fire),
  .merge_hit  (merge_hit),
  .merge_idx  (merge_idx),
  .iss_idx    (iss_idx),
  .valid_q    (valid_q)
);

// File: tb/warp_merge_pool_bench.sv
module warp_merge_pool_bench;
  localparam int ENTRIES = 8;
  localparam int LANES   = 8;
  localparam int PC_W    = 16;
  localparam int TID_W   = 8;
  localparam int TIDS_W  = LANES * TID_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [PC_W-1:0]   in_pc = '0;
  logic [LANES-1:0]  in_mask = '0;
  logic [TIDS_W-1:0] in_tids = '0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [PC_W-1:0]   out_pc;
  logic [LANES-1:0]  out_mask;
  logic [TIDS_W-1:0] out_tids;

  warp_merge_pool #(
    .ENTRIES(ENTRIES), .LANES(LANES), .PC_W(PC_W), .TID_W(TID_W)
  ) u_warp_merge_pool (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_pc(in_pc),
    .in_mask(in_mask), .in_tids(in_tids),
    .out_valid(out_valid), .out_ready(out_ready), .out_pc(out_pc),
    .out_mask(out_mask), .out_tids(out_tids)
  );

  int n_chk  = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference pool built from the requirements
  bit                m_v    [ENTRIES];
  logic [PC_W-1:0]   m_pc   [ENTRIES];
  logic [LANES-1:0]  m_mask [ENTRIES];
  logic [TIDS_W-1:0] m_tid  [ENTRIES];

  typedef struct {
    logic [PC_W-1:0]   pc;
    logic [LANES-1:0]  mask;
    logic [TIDS_W-1:0] tids;
    string             req;
  } item_t;
  item_t sb[$];

  function automatic logic [TIDS_W-1:0] mk_tids(input int base);
    logic [TIDS_W-1:0] t;
    for (int k = 0; k < LANES; k++) t[k*TID_W +: TID_W] = TID_W'(base + k);
    return t;
  endfunction

  // returns target entry or -1; merge tells whether it is a fold
  function automatic int model_target(input logic [PC_W-1:0] pc, input logic [LANES-1:0] mask,
                                      input int excl, output bit merge);
    merge = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      if (m_v[i] && i != excl && m_pc[i] == pc && (m_mask[i] & mask) == '0) begin
        merge = 1'b1;
        return i;
      end
    for (int i = 0; i < ENTRIES; i++)
      if (!m_v[i]) return i;
    return -1;
  endfunction

  task automatic model_apply(input int idx, input bit merge, input logic [PC_W-1:0] pc,
                             input logic [LANES-1:0] mask, input logic [TIDS_W-1:0] tids);
    if (!merge) begin
      m_v[idx] = 1'b1; m_pc[idx] = pc; m_mask[idx] = '0; m_tid[idx] = '0;
    end
    m_mask[idx] |= mask;
    for (int k = 0; k < LANES; k++)
      if (mask[k]) m_tid[idx][k*TID_W +: TID_W] = tids[k*TID_W +: TID_W];
  endtask

  function automatic int model_pick();
    int best = -1;
    for (int i = 0; i < ENTRIES; i++)
      if (m_v[i] && (best < 0 || $countones(m_mask[i]) > $countones(m_mask[best]))) best = i;
    return best;
  endfunction

  // driver: one insert attempt held for one cycle, out_ready kept low
  task automatic insert(input logic [PC_W-1:0] pc, input logic [LANES-1:0] mask,
                        input int base, input string req);
    bit merge;
    int idx;
    bit exp_rdy;
    logic [TIDS_W-1:0] t;
    t = mk_tids(base);
    @(negedge clk);
    in_valid = 1'b1; in_pc = pc; in_mask = mask; in_tids = t;
    #2;
    idx = model_target(pc, mask, -1, merge);
    exp_rdy = (mask == '0) || (idx >= 0);
    check(in_ready == exp_rdy, req, "in_ready", 64'(in_ready), 64'(exp_rdy));
    if (exp_rdy && mask != '0) model_apply(idx, merge, pc, mask, t);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // push the expected issue order, then open out_ready until it drains
  task automatic drain(input string req);
    item_t e;
    for (int p = model_pick(); p >= 0; p = model_pick()) begin
      e.pc = m_pc[p]; e.mask = m_mask[p]; e.tids = m_tid[p]; e.req = req;
      sb.push_back(e);
      m_v[p] = 1'b0;
    end
    @(negedge clk);
    out_ready = 1'b1;
    for (int k = 0; k < 40 && sb.size() > 0; k++) @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    #2;
    check(sb.size() == 0, req, "items left unissued", 64'(sb.size()), 64'd0);
    check(out_valid == 1'b0, req, "out_valid after drain", 64'(out_valid), 64'd0);
  endtask

  // monitor: compares each accepted warp with the scoreboard head
  always @(negedge clk) begin
    item_t e;
    #2;
    if (rst_n && out_valid && out_ready) begin
      if (sb.size() == 0) begin
        check(1'b0, "R6", "issue with nothing expected", 64'(out_pc), 64'd0);
      end else begin
        e = sb.pop_front();
        check(out_pc == e.pc, {e.req, " R5"}, "out_pc", 64'(out_pc), 64'(e.pc));
        check(out_mask == e.mask, {e.req, " R5"}, "out_mask", 64'(out_mask), 64'(e.mask));
        check(out_tids == e.tids, {e.req, " R9"}, "out_tids", 64'(out_tids), 64'(e.tids));
      end
    end
  end

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [PC_W-1:0]  hold_pc;
    logic [LANES-1:0] hold_mask;
    bit merge;
    int idx;
    for (int i = 0; i < ENTRIES; i++) begin
      m_v[i] = 1'b0; m_pc[i] = '0; m_mask[i] = '0; m_tid[i] = '0;
    end

    // R1: reset state
    in_pc = 16'h0abc; in_mask = 8'hff;
    repeat (3) @(posedge clk);
    #1 check(out_valid == 1'b0, "R1", "out_valid in reset", 64'(out_valid), 64'd0);
    @(negedge clk) rst_n = 1'b1;
    #2;
    check(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", 64'(in_ready), 64'd1);
    in_mask = '0;

    // R2 / R3: fold disjoint same-PC warps, split overlapping and other PCs
    insert(16'h0040, 8'h0f, 8'h10, "R2");
    insert(16'h0040, 8'h30, 8'h20, "R2");
    insert(16'h0040, 8'h01, 8'h30, "R3");
    insert(16'h0080, 8'hc0, 8'h40, "R3");
    insert(16'h0040, 8'hc0, 8'h50, "R2");
    drain("R2");

    // R8: empty mask is accepted and dropped
    insert(16'h0040, 8'h00, 8'h60, "R8");
    #1 check(out_valid == 1'b0, "R8", "entry from empty mask", 64'(out_valid), 64'd0);

    // R5: equal counts resolve to the lower index
    insert(16'h0100, 8'h03, 8'h70, "R5");
    insert(16'h0200, 8'h0c, 8'h80, "R5");
    insert(16'h0300, 8'h10, 8'h90, "R5");
    // R6: offer held while out_ready is low
    @(negedge clk); #2;
    hold_pc = out_pc; hold_mask = out_mask;
    repeat (3) @(negedge clk);
    #2;
    check(out_pc == hold_pc, "R6", "held out_pc", 64'(out_pc), 64'(hold_pc));
    check(out_mask == hold_mask, "R6", "held out_mask", 64'(out_mask), 64'(hold_mask));
    drain("R5");

    // R4: full pool rejects, merges still accepted, empty mask still accepted
    for (int i = 0; i < ENTRIES; i++) insert(PC_W'(16'h0500 + i), 8'h01, 8'ha0 + i, "R4");
    insert(16'h0600, 8'h01, 8'hb0, "R4");
    insert(16'h0504, 8'h01, 8'hb8, "R4");
    insert(16'h0500, 8'h00, 8'hc0, "R8");
    insert(16'h0503, 8'h02, 8'hc8, "R4");
    drain("R4");

    // R7: issue and same-PC disjoint insert in one cycle
    insert(16'h0700, 8'h0f, 8'hd0, "R7");
    sb.push_back('{pc: 16'h0700, mask: 8'h0f, tids: m_tid[0], req: "R7"});
    m_v[0] = 1'b0;
    @(negedge clk);
    out_ready = 1'b1;
    in_valid = 1'b1; in_pc = 16'h0700; in_mask = 8'hf0; in_tids = mk_tids(8'he0);
    #2;
    check(in_ready == 1'b1, "R7", "in_ready during issue", 64'(in_ready), 64'd1);
    idx = model_target(16'h0700, 8'hf0, 0, merge);
    model_apply(idx, merge, 16'h0700, 8'hf0, mk_tids(8'he0));
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b0;
    #2;
    check(out_mask == 8'hf0, "R7", "remaining warp mask", 64'(out_mask), 64'hf0);
    drain("R7");

    repeat (2) @(posedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule